// File: doc/BRIEF.md
# Programmable Offset Pulse-Per-Second Generator

This block divides a fast oscillator clock (200 MHz by default, 5 ns per cycle) into a family of timing pulses that share one second boundary. A reference once-per-second pulse and pulses at ten, one hundred and one thousand per second all come from one divider chain, so every rate output rises on the same cycle as the reference. Every pulse is high for 20 us, which is 4000 cycles at the default clock.

A second once-per-second output, the delayed pulse, starts a programmable number of whole clock cycles after the reference. The offset can reach anywhere within the second. A host loads the offset through a three-wire serial shift interface: clock, data and latch. The same word also carries an 8-bit fine-delay code. That code is driven unchanged on a parallel port, where an external interpolating delay element can use it to place the pulse between adjacent clock steps. New settings wait for the next second boundary, so no pulse is cut short or doubled by a reload.

Top module: `pps_offset_gen`

## Requirements
- R1: While `rst` is high at a rising clock edge, every pulse output and `fine_o` are 0 after that edge. Reset also loads a zero offset, so in the first second after reset `pps_dly_o` matches `pps_ref_o`.
- R2: Number the rising edges from 0, starting with the first edge at which `rst` is low. After edge k, `pps_ref_o` is 1 exactly when k mod SEC_CNT < PULSE_W.
- R3: After edge k, `rate_o[0]` is 1 exactly when k mod (SEC_CNT/10) < PULSE_W. `rate_o[1]` uses SEC_CNT/100 as the period and `rate_o[2]` uses SEC_CNT/1000.
- R4: With an active offset D, `pps_dly_o` goes high after edge k when k mod SEC_CNT equals D. It then stays high for PULSE_W cycles.
- R5: A word is loaded serially, most significant bit first. `ser_dat` is sampled on each rising edge of `ser_clk`, and a rising edge of `ser_lat` captures the last OFS_W+FINE_W bits shifted in. The upper OFS_W bits are the coarse offset and the lower FINE_W bits are the fine code. Bits shifted in before those are discarded.
- R6: A captured word takes effect at the edge where the main count moves from SEC_CNT-1 to 0. `fine_o` changes on that edge, one cycle before `pps_ref_o` rises. Any delayed pulse still due in the current second uses the old offset.
- R7: A coarse offset of SEC_CNT or more acts as that value minus SEC_CNT. The parameters must keep 2^OFS_W at or below 2·SEC_CNT.
- R8: An offset of SEC_CNT-1 starts the delayed pulse on the last count of the second. That pulse then runs its full PULSE_W cycles into the following second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial shift clock from host (asynchronous) |
| ser_dat | input | 1 | Serial data, most significant bit first |
| ser_lat | input | 1 | Latch strobe; its rising edge captures the shift word |
| pps_ref_o | output | 1 | Reference once-per-second pulse |
| rate_o | output | 3 | Aligned pulses: bit 0 ten, bit 1 one hundred, bit 2 one thousand per second |
| pps_dly_o | output | 1 | Delayed once-per-second pulse |
| fine_o | output | FINE_W | Fine-delay code for the external interpolator |

## Verification
The hardest case to reach from the ports is a reload that lands while a second is under way. A correct design must leave that second's delayed pulse in the old position and move it only after the boundary. The bench shrinks the second to 20000 cycles and loads a new offset partway through a second, at a point where applying it at once would produce an extra pulse. It compares every output on every cycle against positions computed from edge numbers. Other loads put extra leading bits ahead of the word, use an offset larger than the second, and use the last count of the second. The last of these leaves a pulse running across the wrap.

// File: rtl/pps_pkg.sv
package pps_pkg;

    // number of decimal sub-rates below one pulse per second (10, 100, 1000)
    localparam int RATE_COUNT = 3;

    // period in clock cycles of sub-rate idx: sec / 10^(idx+1)
    function automatic int unsigned rate_div(input int unsigned sec, input int idx);
        int unsigned d;
        d = sec;
        for (int j = 0; j <= idx; j++) begin
            d = d / 10;
        end
        return d;
    endfunction

endpackage

// File: rtl/pps_pulse_gen.sv
module pps_pulse_gen #(
    parameter int unsigned WIDTH = 4000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic pulse_o
);
    localparam int LW = $clog2(WIDTH + 1);

    typedef struct packed {
        logic [LW-1:0] left;
        logic          out;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (start) begin
            s_d.left = LW'(WIDTH - 1);
            s_d.out  = 1'b1;
        end else if (s_q.left != '0) begin
            s_d.left = s_q.left - 1'b1;
            s_d.out  = 1'b1;
        end else begin
            s_d.out  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign pulse_o = s_q.out;

endmodule

// File: rtl/pps_serial_load.sv
module pps_serial_load #(
    parameter int WORD_W = 36,
    parameter int SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_clk,
    input  logic              ser_dat,
    input  logic              ser_lat,
    output logic [WORD_W-1:0] word_o,
    output logic              vld_o
);
    typedef struct packed {
        logic [SYNC_N:0]   ck;
        logic [SYNC_N:0]   dt;
        logic [SYNC_N:0]   lt;
        logic [WORD_W-1:0] sh;
        logic              vld;
    } st_t;

    st_t  s_d, s_q;
    logic ck_rise, lt_rise;

    assign ck_rise = s_q.ck[SYNC_N-1] & ~s_q.ck[SYNC_N];
    assign lt_rise = s_q.lt[SYNC_N-1] & ~s_q.lt[SYNC_N];

    always_comb begin
        s_d    = s_q;
        s_d.ck = {s_q.ck[SYNC_N-1:0], ser_clk};
        s_d.dt = {s_q.dt[SYNC_N-1:0], ser_dat};
        s_d.lt = {s_q.lt[SYNC_N-1:0], ser_lat};
        if (ck_rise) begin
            s_d.sh = {s_q.sh[WORD_W-2:0], s_q.dt[SYNC_N-1]};
        end
        s_d.vld = lt_rise;
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign word_o = s_q.sh;
    assign vld_o  = s_q.vld;

endmodule

// File: rtl/pps_offset_gen.sv
module pps_offset_gen #(
    parameter int unsigned SEC_CNT = 200_000_000,
    parameter int unsigned PULSE_W = 4000,
    parameter int          OFS_W   = 28,
    parameter int          FINE_W  = 8,
    parameter int          SYNC_N  = 2
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            ser_clk,
    input  logic                            ser_dat,
    input  logic                            ser_lat,
    output logic                            pps_ref_o,
    output logic [pps_pkg::RATE_COUNT-1:0]  rate_o,
    output logic                            pps_dly_o,
    output logic [FINE_W-1:0]               fine_o
);
    localparam int              CNT_W   = $clog2(SEC_CNT);
    localparam int              WORD_W  = OFS_W + FINE_W;
    localparam logic [OFS_W:0]  SEC_EXT = (OFS_W + 1)'(SEC_CNT);
    localparam logic [CNT_W-1:0] LAST   = CNT_W'(SEC_CNT - 1);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  ofs_act;
        logic [FINE_W-1:0] fine_act;
        logic [CNT_W-1:0]  pend_ofs;
        logic [FINE_W-1:0] pend_fine;
        logic              pend_vld;
    } st_t;

    st_t               s_d, s_q;
    logic [WORD_W-1:0] word;
    logic              word_vld;
    logic              wrap;
    logic [OFS_W:0]    raw_ext;
    logic [OFS_W:0]    red;

    pps_serial_load #(.WORD_W(WORD_W), .SYNC_N(SYNC_N)) u_ser (
        .clk     (clk),
        .rst     (rst),
        .ser_clk (ser_clk),
        .ser_dat (ser_dat),
        .ser_lat (ser_lat),
        .word_o  (word),
        .vld_o   (word_vld)
    );

    assign wrap = (s_q.cnt == LAST);

    // fold an out-of-range coarse offset back into the second
    always_comb begin
        raw_ext = {1'b0, word[WORD_W-1:FINE_W]};
        if (raw_ext >= SEC_EXT) red = raw_ext - SEC_EXT;
        else                    red = raw_ext;
    end

    always_comb begin
        s_d     = s_q;
        s_d.cnt = wrap ? '0 : s_q.cnt + 1'b1;
        if (wrap && s_q.pend_vld) begin
            s_d.ofs_act  = s_q.pend_ofs;
            s_d.fine_act = s_q.pend_fine;
            s_d.pend_vld = 1'b0;
        end
        if (word_vld) begin
            s_d.pend_ofs  = CNT_W'(red);
            s_d.pend_fine = word[FINE_W-1:0];
            s_d.pend_vld  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    pps_pulse_gen #(.WIDTH(PULSE_W)) u_ref (
        .clk(clk), .rst(rst), .start(s_q.cnt == '0), .pulse_o(pps_ref_o)
    );

    pps_pulse_gen #(.WIDTH(PULSE_W)) u_dly (
        .clk(clk), .rst(rst), .start(s_q.cnt == s_q.ofs_act), .pulse_o(pps_dly_o)
    );

    for (genvar i = 0; i < pps_pkg::RATE_COUNT; i++) begin : g_rate
        localparam int unsigned DIV = pps_pkg::rate_div(SEC_CNT, i);
        localparam int          DW  = $clog2(DIV);
        logic [DW-1:0] sc_d, sc_q;

        always_comb begin
            if (wrap || sc_q == DW'(DIV - 1)) sc_d = '0;
            else                              sc_d = sc_q + 1'b1;
        end

        always_ff @(posedge clk) begin
            if (rst) sc_q <= '0;
            else     sc_q <= sc_d;
        end

        pps_pulse_gen #(.WIDTH(PULSE_W)) u_pg (
            .clk(clk), .rst(rst), .start(sc_q == '0), .pulse_o(rate_o[i])
        );
    end

    assign fine_o = s_q.fine_act;

endmodule

// File: rtl/pps_offset_chk.sv
module pps_offset_chk #(
    parameter int unsigned PULSE_W = 4000,
    parameter int          FINE_W  = 8
) (
    input logic                           clk,
    input logic                           rst,
    input logic                           pps_ref_o,
    input logic [pps_pkg::RATE_COUNT-1:0] rate_o,
    input logic                           pps_dly_o,
    input logic [FINE_W-1:0]              fine_o
);
    logic [31:0] run_q;
    logic        rst_seen_q;

    always_ff @(posedge clk) begin
        rst_seen_q <= rst;
        if (rst)            run_q <= '0;
        else if (pps_ref_o) run_q <= run_q + 1;
        else                run_q <= '0;
    end

    // R1: outputs cleared after an edge with reset high
    always_ff @(negedge clk) begin
        if (rst_seen_q) begin
            a_r1_reset_low: assert (!pps_ref_o && !pps_dly_o && rate_o == '0 && fine_o == '0)
                else $error("R1 outputs not cleared by reset");
        end
    end

    // R2: reference pulse lasts exactly PULSE_W cycles
    a_r2_ref_width: assert property (@(posedge clk) disable iff (rst)
        $fell(pps_ref_o) |-> run_q == PULSE_W);

    // R3: each slower rate rises together with all faster rates; the second with all
    a_r3_ref_aligned: assert property (@(posedge clk) disable iff (rst)
        $rose(pps_ref_o) |-> rate_o == '1);
    a_r3_ten_in_hundred: assert property (@(posedge clk) disable iff (rst)
        $rose(rate_o[0]) |-> $rose(rate_o[1]));
    a_r3_hundred_in_thousand: assert property (@(posedge clk) disable iff (rst)
        $rose(rate_o[1]) |-> $rose(rate_o[2]));

    // R6: fine code moves only on the boundary, one cycle ahead of the reference rise
    a_r6_fine_at_boundary: assert property (@(posedge clk) disable iff (rst)
        !$stable(fine_o) |=> $rose(pps_ref_o));

endmodule

bind pps_offset_gen pps_offset_chk #(.PULSE_W(PULSE_W), .FINE_W(FINE_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .pps_ref_o (pps_ref_o),
    .rate_o    (rate_o),
    .pps_dly_o (pps_dly_o),
    .fine_o    (fine_o)
);

// File: tb/pps_offset_gen_test.sv
module pps_offset_gen_test;
    localparam int N  = 20000;
    localparam int PW = 5;
    localparam int OW = 15;
    localparam int FW = 8;
    localparam int END_EDGES = 80010;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ser_clk = 1'b0;
    logic          ser_dat = 1'b0;
    logic          ser_lat = 1'b0;
    logic          pps_ref_o;
    logic [2:0]    rate_o;
    logic          pps_dly_o;
    logic [FW-1:0] fine_o;

    int checks = 0;
    int fails  = 0;
    int edges  = 0;
    bit done   = 1'b0;

    // bench model state
    int   m_ofs = 0;
    int   m_fine = 0;
    int   m_pend_ofs = 0;
    int   m_pend_fine = 0;
    bit   m_pend_vld = 1'b0;
    int   m_last = 0;
    bit   m_started = 1'b0;
    bit   e_ref, e_dly;
    bit [2:0] e_rate;
    int   e_fine;

    always #5 clk = ~clk;

    pps_offset_gen #(.SEC_CNT(N), .PULSE_W(PW), .OFS_W(OW), .FINE_W(FW)) uut (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_lat(ser_lat),
        .pps_ref_o(pps_ref_o), .rate_o(rate_o), .pps_dly_o(pps_dly_o), .fine_o(fine_o)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            if (fails < 40)
                $display("FAIL %s %s at edge %0d: got %0h expected %0h", tag, what, edges - 1, act, exp);
        end
    endtask

    // expected values after edge k, from edge arithmetic
    always @(posedge clk) begin
        if (!rst) begin
            int k;
            k = edges;
            edges = edges + 1;
            if ((k % N) == m_ofs) begin
                m_last = k;
                m_started = 1'b1;
            end
            if ((k % N) == N - 1 && m_pend_vld) begin
                m_ofs = m_pend_ofs;
                m_fine = m_pend_fine;
                m_pend_vld = 1'b0;
            end
            e_ref     = (k % N) < PW;
            e_rate[0] = (k % (N / 10)) < PW;
            e_rate[1] = (k % (N / 100)) < PW;
            e_rate[2] = (k % (N / 1000)) < PW;
            e_dly     = m_started && (k - m_last) < PW;
            e_fine    = m_fine;
        end
    end

    function automatic string dly_tag(input int k);
        if (k < N)              return "R4";
        else if (m_last < 2*N)  return "R6";
        else if (m_last < 3*N)  return "R7";
        else                    return "R8";
    endfunction

    always @(negedge clk) begin
        if (!rst && edges > 0 && !done) begin
            check("R2", "pps_ref_o", int'(pps_ref_o), int'(e_ref));
            check("R3", "rate_o[0]", int'(rate_o[0]), int'(e_rate[0]));
            check("R3", "rate_o[1]", int'(rate_o[1]), int'(e_rate[1]));
            check("R3", "rate_o[2]", int'(rate_o[2]), int'(e_rate[2]));
            check(dly_tag(edges - 1), "pps_dly_o", int'(pps_dly_o), int'(e_dly));
            check((edges < 2*N) ? "R5" : "R6", "fine_o", int'(fine_o), e_fine);
        end
    end

    // shift nbits of v MSB first, then strobe the latch
    task automatic load(input logic [63:0] v, input int nbits, input int ofs_eff, input int fine);
        for (int i = nbits - 1; i >= 0; i--) begin
            @(negedge clk);
            ser_dat = v[i];
            ser_clk = 1'b0;
            repeat (4) @(negedge clk);
            ser_clk = 1'b1;
            repeat (4) @(negedge clk);
            ser_clk = 1'b0;
        end
        repeat (4) @(negedge clk);
        ser_lat = 1'b1;
        repeat (4) @(negedge clk);
        ser_lat = 1'b0;
        repeat (8) @(negedge clk);
        m_pend_ofs  = ofs_eff;
        m_pend_fine = fine;
        m_pend_vld  = 1'b1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check("R1", "pps_ref_o", int'(pps_ref_o), 0);
        check("R1", "pps_dly_o", int'(pps_dly_o), 0);
        check("R1", "rate_o", int'(rate_o), 0);
        check("R1", "fine_o", int'(fine_o), 0);
        rst = 1'b0;

        // R5: four junk bits ahead of the word must be discarded; offset 7, fine A5
        wait (edges >= 1000);
        load({37'd0, 4'b1011, 15'd7, 8'hA5}, 4 + OW + FW, 7, 'hA5);

        // R6/R7: mid-second reload of 25000 folds to 5000, must not act before the boundary
        wait (edges >= 22000);
        load({41'd0, 15'd25000, 8'h3C}, OW + FW, 5000, 'h3C);

        // R8: last count of the second; pulse crosses the wrap
        wait (edges >= 45000);
        load({41'd0, 15'd19999, 8'hFF}, OW + FW, 19999, 'hFF);

        wait (edges >= END_EDGES);
        @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(1_900_000);
        if (!done) begin
            done = 1'b1;
            fails++;
            checks++;
            $display("FAIL watchdog expired at edge %0d: got running expected finished", edges);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule